// File: doc/BRIEF.md
# I2C Event Flag and Interrupt Unit

This block keeps the seven event flags of an I2C controller and combines them into a single interrupt request. The protocol engine sends one-cycle pulses when something happens on the bus: a byte arrived, the transmit register needs a byte, a stop condition was seen, a reload of the byte count is needed, the transfer finished, the own address matched, or a NACK came back. Each pulse sets its flag. The flag then stays set until software performs the access that belongs to that flag.

Software clears the flags through the register strobes of a simple bus interface. The clearing actions differ from flag to flag:

- Reading the receive data register clears the receive flag.
- Writing the transmit data register clears the transmit flag.
- Three flags clear on a write of one to their own clear bit.
- The reload flag clears on a control write that carries a nonzero byte count.
- The transfer-complete flag clears on a control write that requests a start or a stop.

A six-bit enable word gates the flags onto a level-sensitive interrupt line. A flag still sets while its enable is off. This allows DMA-driven reception, where data register reads alone keep the receive flag in step.

Top module: `i2c_evt_irq`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears all seven flags and all six enable bits, and `irq` is then low.
- R2: Flag bit 0 (receive full) sets on `ev_rx_full` and clears only on `rd_rxdata`.
- R3: Flag bit 1 (transmit empty) sets on `ev_tx_empty` and clears only on `wr_txdata`.
- R4: On `wr_clear`, `clear_bits[0]` = 1 clears flag bit 2 (stop), `clear_bits[1]` = 1 clears flag bit 5 (address hit), and `clear_bits[2]` = 1 clears flag bit 6 (NACK). A clear bit written as zero leaves its flag unchanged.
- R5: Flag bit 3 (reload) clears only on `wr_ctl2` with `ctl2_count` not equal to zero. A control write with a zero count leaves it set.
- R6: Flag bit 4 (transfer complete) clears only on `wr_ctl2` with `ctl2_start` or `ctl2_stop` high.
- R7: When a flag's set pulse and its clearing action occur in the same cycle, the flag ends up set.
- R8: The enables are loaded from `enable_bits` on `wr_enable`. Their bits are: 0 receive, 1 transmit, 2 stop, 3 shared by reload and transfer complete, 4 address hit, 5 NACK.
- R9: `irq` is high exactly when some flag is set and its enable bit is set. It follows the registered flags and enables with no further delay.
- R10: Flags set and hold regardless of the enables. A clearing action of one flag leaves every other flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_rx_full | input | 1 | Pulse: byte loaded into receive register |
| ev_tx_empty | input | 1 | Pulse: transmit register needs data |
| ev_stop | input | 1 | Pulse: stop condition detected |
| ev_reload | input | 1 | Pulse: byte count exhausted, reload needed |
| ev_done | input | 1 | Pulse: transfer complete |
| ev_addr_hit | input | 1 | Pulse: own address matched |
| ev_nack | input | 1 | Pulse: NACK received |
| rd_rxdata | input | 1 | Strobe: receive data register read |
| wr_txdata | input | 1 | Strobe: transmit data register write |
| wr_ctl2 | input | 1 | Strobe: control register 2 write |
| ctl2_count | input | CNT_W | Byte-count field of the control write |
| ctl2_start | input | 1 | Start request bit of the control write |
| ctl2_stop | input | 1 | Stop request bit of the control write |
| wr_clear | input | 1 | Strobe: clear register write |
| clear_bits | input | 3 | Clear bits: 0 stop, 1 address hit, 2 NACK |
| wr_enable | input | 1 | Strobe: enable register write |
| enable_bits | input | 6 | New enable word |
| flags | output | 7 | Flag status: 0 rx, 1 tx, 2 stop, 3 reload, 4 done, 5 addr, 6 NACK |
| irq_en | output | 6 | Current enable word |
| irq | output | 1 | Combined interrupt request |

## Verification
A flag's set pulse and its own clearing action can fall in the same cycle. So can one flag's clearing action and another flag's set pulse. The bench first sets every flag. It then applies each of the eleven software actions, either alone or together with the set pulse of one chosen flag, for every one of the seven flags. It compares the whole flag vector with an expected value built from a per-action clear mask, where the chosen flag survives whenever its pulse was present. A second sweep loads all 64 enable words against all 128 flag patterns and compares `irq` with an arithmetically derived OR.

// File: rtl/i2c_evt_irq.sv
module i2c_evt_irq #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_rx_full,
  input  logic             ev_tx_empty,
  input  logic             ev_stop,
  input  logic             ev_reload,
  input  logic             ev_done,
  input  logic             ev_addr_hit,
  input  logic             ev_nack,
  input  logic             rd_rxdata,
  input  logic             wr_txdata,
  input  logic             wr_ctl2,
  input  logic [CNT_W-1:0] ctl2_count,
  input  logic             ctl2_start,
  input  logic             ctl2_stop,
  input  logic             wr_clear,
  input  logic [2:0]       clear_bits,
  input  logic             wr_enable,
  input  logic [5:0]       enable_bits,
  output logic [6:0]       flags,
  output logic [5:0]       irq_en,
  output logic             irq
);

  logic [6:0] set_v, clr_v, gate_v;

  assign set_v = {ev_nack, ev_addr_hit, ev_done, ev_reload,
                  ev_stop, ev_tx_empty, ev_rx_full};

  assign clr_v[0] = rd_rxdata;
  assign clr_v[1] = wr_txdata;
  assign clr_v[2] = wr_clear & clear_bits[0];
  assign clr_v[3] = wr_ctl2 & (ctl2_count != '0);
  assign clr_v[4] = wr_ctl2 & (ctl2_start | ctl2_stop);
  assign clr_v[5] = wr_clear & clear_bits[1];
  assign clr_v[6] = wr_clear & clear_bits[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      flags  <= '0;
      irq_en <= '0;
    end else begin
      flags <= set_v | (flags & ~clr_v);
      if (wr_enable) irq_en <= enable_bits;
    end
  end

  assign gate_v = {irq_en[5], irq_en[4], irq_en[3], irq_en[3],
                   irq_en[2], irq_en[1], irq_en[0]};
  assign irq = |(flags & gate_v);

  a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
    (set_v != '0) |=> ((flags & $past(set_v)) == $past(set_v)));

  a_r2_rx_hold: assert property (@(posedge clk) disable iff (rst)
    (flags[0] && !rd_rxdata) |=> flags[0]);

  a_r3_tx_hold: assert property (@(posedge clk) disable iff (rst)
    (flags[1] && !wr_txdata) |=> flags[1]);

  a_r5_reload_hold: assert property (@(posedge clk) disable iff (rst)
    (flags[3] && !(wr_ctl2 && ctl2_count != '0)) |=> flags[3]);

  a_r6_done_hold: assert property (@(posedge clk) disable iff (rst)
    (flags[4] && !(wr_ctl2 && (ctl2_start || ctl2_stop))) |=> flags[4]);

  a_r4_addr_hold: assert property (@(posedge clk) disable iff (rst)
    (flags[5] && !(wr_clear && clear_bits[1])) |=> flags[5]);

  a_r8_en_stable: assert property (@(posedge clk) disable iff (rst)
    !wr_enable |=> $stable(irq_en));

endmodule

// File: tb/i2c_evt_irq_test.sv
`timescale 1ns/1ps
module i2c_evt_irq_test;
  logic clk = 0;
  logic rst = 1;
  logic [6:0] ev = '0;
  logic rd_rxdata = 0, wr_txdata = 0, wr_ctl2 = 0, ctl2_start = 0, ctl2_stop = 0;
  logic [7:0] ctl2_count = '0;
  logic wr_clear = 0, wr_enable = 0;
  logic [2:0] clear_bits = '0;
  logic [5:0] enable_bits = '0;
  logic [6:0] flags;
  logic [5:0] irq_en;
  logic irq;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  i2c_evt_irq uut (
    .clk(clk), .rst(rst),
    .ev_rx_full(ev[0]), .ev_tx_empty(ev[1]), .ev_stop(ev[2]), .ev_reload(ev[3]),
    .ev_done(ev[4]), .ev_addr_hit(ev[5]), .ev_nack(ev[6]),
    .rd_rxdata(rd_rxdata), .wr_txdata(wr_txdata), .wr_ctl2(wr_ctl2),
    .ctl2_count(ctl2_count), .ctl2_start(ctl2_start), .ctl2_stop(ctl2_stop),
    .wr_clear(wr_clear), .clear_bits(clear_bits),
    .wr_enable(wr_enable), .enable_bits(enable_bits),
    .flags(flags), .irq_en(irq_en), .irq(irq));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    ev = '0; rd_rxdata = 0; wr_txdata = 0; wr_ctl2 = 0; ctl2_start = 0;
    ctl2_stop = 0; ctl2_count = '0; wr_clear = 0; clear_bits = '0; wr_enable = 0;
  endtask

  function automatic logic [6:0] clr_mask(input int a);
    case (a)
      1: return 7'b0000001;
      2: return 7'b0000010;
      4: return 7'b0001000;
      5, 6: return 7'b0010000;
      7: return 7'b0000100;
      8: return 7'b0100000;
      9: return 7'b1000000;
      default: return 7'b0;
    endcase
  endfunction

  task automatic apply(input int a);
    case (a)
      1: rd_rxdata = 1;
      2: wr_txdata = 1;
      3: begin wr_ctl2 = 1; ctl2_count = 0; end
      4: begin wr_ctl2 = 1; ctl2_count = 5; end
      5: begin wr_ctl2 = 1; ctl2_start = 1; end
      6: begin wr_ctl2 = 1; ctl2_stop = 1; end
      7: begin wr_clear = 1; clear_bits = 3'b001; end
      8: begin wr_clear = 1; clear_bits = 3'b010; end
      9: begin wr_clear = 1; clear_bits = 3'b100; end
      10: begin wr_clear = 1; clear_bits = 3'b000; end
      default: ;
    endcase
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [6:0] expv;
    logic [6:0] g;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 0;
    @(negedge clk);
    chk("R1 flags", flags, 0);
    chk("R1 enables", irq_en, 0);
    chk("R1 irq", irq, 0);

    for (int f = 0; f < 7; f++)
      for (int a = 0; a < 11; a++)
        for (int s = 0; s < 2; s++) begin
          idle(); ev = 7'h7f;
          @(negedge clk);
          idle(); apply(a);
          if (s == 1) ev[f] = 1'b1;
          @(negedge clk);
          idle();
          expv = 7'h7f & ~clr_mask(a);
          if (s == 1) expv[f] = 1'b1;
          chk((s == 1) ? "R7 set wins" : "R2 R3 R4 R5 R6 R10 clear action",
              flags, expv);
          chk("R9 no irq with enables off", irq, 0);
        end

    for (int e = 0; e < 64; e++)
      for (int p = 0; p < 128; p++) begin
        idle(); rst = 1;
        @(negedge clk);
        rst = 0; wr_enable = 1; enable_bits = e[5:0]; ev = p[6:0];
        @(negedge clk);
        idle();
        g = {e[5], e[4], e[3], e[3], e[2], e[1], e[0]};
        chk("R8 enable load", irq_en, e);
        chk("R10 flags independent of enables", flags, p);
        chk("R9 irq", irq, ((p[6:0] & g) != 0) ? 1 : 0);
      end

    idle(); rst = 1;
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 reset after use", {irq, irq_en, flags}, 0);
    finish_run();
  end
endmodule